// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block moves a run of bytes or 16-bit words between one peripheral port and a stretch of memory. A start command carries five things. The first is the port address, which stays the same for the whole run. The second is the first memory address, which steps after every element. The third is the element count, and the fourth is the element size. The last is the transfer direction, together with whether the memory address rises or falls.

Each element takes one I/O bus cycle and one memory bus cycle. Each request is held until its ready input answers. The block moves word data onto the data-bus byte lanes that the peripheral side expects. Between elements, an interrupt request can park the sequencer. A resume pulse then continues the run from the held address and count.

A word request is refused when the bus is strapped to 8 bits and the port lies outside the on-chip peripheral window.

Top module: `blkio_seq`

## Requirements
- R1: Every I/O request of a run presents the port address given at start, unchanged until the run ends.
- R2: After each element the memory address moves by 1 in byte mode or by 2 in word mode. It rises when the start command's decrement select is 0 and falls when it is 1. It wraps modulo 2^MEM_AW.
- R3: The count is in elements: words in word mode, bytes in byte mode. It drops by one per completed element. After the last element, `done` pulses for one cycle and `busy` falls.
- R4: Byte mode, I/O side: a byte read from the port is taken from io_rdata[7:0] only, and a byte written to the port is placed on io_wdata[7:0] with io_wdata[15:8] at zero.
- R5: Byte mode, memory side: a byte read from memory is taken from mem_rdata[7:0] only, and a byte written to memory is placed on mem_wdata[7:0] with mem_wdata[15:8] at zero.
- R6: Word mode: a memory word value V appears on the I/O lanes as {V[7:0], V[15:8]}. Its high byte goes on D7-D0 and its low byte on D15-D8. Port reads are mapped back the same way.
- R7: With input direction (st_input=1) each element is an I/O read, then a memory write. With output direction it is a memory read, then an I/O write. The I/O and memory requests are never active together.
- R8: `irq_req` is sampled only when an element completes. If it is high and elements remain, the block raises `paused`. While paused it issues no request and holds cur_mem and cur_count. A `resume` pulse continues with the next element.
- R9: A word start with bus_narrow=1 and a port outside [ONCHIP_LO, ONCHIP_HI] sets `err` in the next cycle and makes no bus cycle. With a port inside that window, the word start runs normally. `err` is cleared by the next accepted start.
- R10: A start with a count of zero pulses `done` in the next cycle without any bus request.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command, taken when idle |
| st_port | input | PORT_AW | Port address of the run |
| st_mem | input | MEM_AW | First memory address |
| st_count | input | CNT_W | Number of elements |
| st_word | input | 1 | 1 = 16-bit elements, 0 = bytes |
| st_dec | input | 1 | 1 = memory address falls |
| st_input | input | 1 | 1 = port to memory, 0 = memory to port |
| bus_narrow | input | 1 | Data bus strapped to 8 bits |
| irq_req | input | 1 | Interrupt request, sampled at element boundaries |
| resume | input | 1 | Continue a paused run |
| io_req | output | 1 | I/O cycle request |
| io_we | output | 1 | I/O cycle is a write |
| io_word | output | 1 | I/O cycle is 16 bits wide |
| io_addr | output | PORT_AW | I/O port address |
| io_wdata | output | 16 | I/O write data lanes |
| io_rdata | input | 16 | I/O read data lanes |
| io_ready | input | 1 | I/O cycle completes |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_word | output | 1 | Memory cycle is 16 bits wide |
| mem_addr | output | MEM_AW | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory cycle completes |
| busy | output | 1 | A run is in progress, paused or not |
| paused | output | 1 | Run parked at an element boundary |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Last start was a refused word request |
| cur_mem | output | MEM_AW | Current memory address |
| cur_count | output | CNT_W | Elements still to move |

## Verification
The bench builds the block with 8-bit port and memory addresses, a 4-bit count and an on-chip window of 0xF0 to 0xFF. With 8-bit addresses, a falling run that crosses address zero can be tested in a few elements, so the wrap rule of R2 is checked directly. The small window places both an external port (0x12) and an on-chip port (0xF4) inside the same test, so both sides of the narrow-bus refusal are covered. The count width keeps every run short enough to check each element's lanes and the order of its bus cycles.

// File: rtl/blkio_pkg.sv
package blkio_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_IO_RD  = 3'd1,
    S_MEM_WR = 3'd2,
    S_MEM_RD = 3'd3,
    S_IO_WR  = 3'd4,
    S_PAUSE  = 3'd5
  } seq_state_t;

  // Lane mapping between a memory-side value and the I/O data lanes.
  // Word: high byte on the low lane, low byte on the high lane.
  // Byte: only the low lane carries data.
  function automatic logic [15:0] swap_lanes(input logic [15:0] d, input logic word);
    if (word) return {d[7:0], d[15:8]};
    return {8'h00, d[7:0]};
  endfunction

  function automatic logic [15:0] mem_side(input logic [15:0] d, input logic word);
    if (word) return d;
    return {8'h00, d[7:0]};
  endfunction

endpackage

// File: rtl/blkio_regs.sv
module blkio_regs #(
  parameter int PORT_AW = 16,
  parameter int MEM_AW  = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               elem_done,
  input  logic [PORT_AW-1:0] ld_port,
  input  logic [MEM_AW-1:0]  ld_mem,
  input  logic [CNT_W-1:0]   ld_count,
  input  logic               ld_word,
  input  logic               ld_dec,
  input  logic               ld_input,
  output logic [PORT_AW-1:0] port_q,
  output logic [MEM_AW-1:0]  mem_q,
  output logic [CNT_W-1:0]   count_q,
  output logic               word_q,
  output logic               dec_q,
  output logic               input_q,
  output logic               last_elem
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [MEM_AW-1:0] next_addr(
    input logic [MEM_AW-1:0] a, input logic word, input logic dec);
    logic [MEM_AW-1:0] stride;
    stride = word ? MEM_AW'(2) : MEM_AW'(1);
    return dec ? a - stride : a + stride;
  endfunction

  assign last_elem = (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      mem_q   <= '0;
      count_q <= '0;
      word_q  <= 1'b0;
      dec_q   <= 1'b0;
      input_q <= 1'b0;
    end else if (load) begin
      port_q  <= ld_port;
      mem_q   <= ld_mem;
      count_q <= ld_count;
      word_q  <= ld_word;
      dec_q   <= ld_dec;
      input_q <= ld_input;
    end else if (elem_done) begin
      mem_q   <= next_addr(mem_q, word_q, dec_q);
      count_q <= count_q - ONE;
    end
  end

endmodule

// File: rtl/blkio_lane.sv
module blkio_lane
  import blkio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word,
  input  logic        take_io,
  input  logic        take_mem,
  input  logic [15:0] io_rdata,
  input  logic [15:0] mem_rdata,
  output logic [15:0] io_wdata,
  output logic [15:0] mem_wdata
);

  logic [15:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (take_io)  hold_q <= swap_lanes(io_rdata, word);
    else if (take_mem) hold_q <= mem_side(mem_rdata, word);
  end

  assign mem_wdata = hold_q;
  assign io_wdata  = swap_lanes(hold_q, word);

endmodule

// File: rtl/blkio_ctrl.sv
module blkio_ctrl
  import blkio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       refuse,
  input  logic       zero_count,
  input  logic       st_input,
  input  logic       input_q,
  input  logic       last_elem,
  input  logic       irq_req,
  input  logic       resume,
  input  logic       io_ready,
  input  logic       mem_ready,
  output seq_state_t state,
  output logic       load,
  output logic       elem_done,
  output logic       take_io,
  output logic       take_mem,
  output logic       done,
  output logic       err
);

  seq_state_t nxt;
  logic accept, done_set;

  assign accept    = start && (state == S_IDLE);
  assign load      = accept && !refuse && !zero_count;
  assign take_io   = (state == S_IO_RD)  && io_ready;
  assign take_mem  = (state == S_MEM_RD) && mem_ready;
  assign elem_done = ((state == S_MEM_WR) && mem_ready) ||
                     ((state == S_IO_WR)  && io_ready);
  assign done_set  = (accept && !refuse && zero_count) || (elem_done && last_elem);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (load) nxt = st_input ? S_IO_RD : S_MEM_RD;
      S_IO_RD:  if (io_ready)  nxt = S_MEM_WR;
      S_MEM_RD: if (mem_ready) nxt = S_IO_WR;
      S_MEM_WR, S_IO_WR: begin
        if (elem_done) begin
          if (last_elem)    nxt = S_IDLE;
          else if (irq_req) nxt = S_PAUSE;
          else              nxt = input_q ? S_IO_RD : S_MEM_RD;
        end
      end
      S_PAUSE:  if (resume) nxt = input_q ? S_IO_RD : S_MEM_RD;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= done_set;
      if (accept) err <= refuse;
    end
  end

endmodule

// File: rtl/blkio_seq.sv
module blkio_seq
  import blkio_pkg::*;
#(
  parameter int PORT_AW = 16,
  parameter int MEM_AW  = 16,
  parameter int CNT_W   = 16,
  parameter logic [PORT_AW-1:0] ONCHIP_LO = 16'hFF00,
  parameter logic [PORT_AW-1:0] ONCHIP_HI = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PORT_AW-1:0] st_port,
  input  logic [MEM_AW-1:0]  st_mem,
  input  logic [CNT_W-1:0]   st_count,
  input  logic               st_word,
  input  logic               st_dec,
  input  logic               st_input,
  input  logic               bus_narrow,
  input  logic               irq_req,
  input  logic               resume,
  output logic               io_req,
  output logic               io_we,
  output logic               io_word,
  output logic [PORT_AW-1:0] io_addr,
  output logic [15:0]        io_wdata,
  input  logic [15:0]        io_rdata,
  input  logic               io_ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_word,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [15:0]        mem_wdata,
  input  logic [15:0]        mem_rdata,
  input  logic               mem_ready,
  output logic               busy,
  output logic               paused,
  output logic               done,
  output logic               err,
  output logic [MEM_AW-1:0]  cur_mem,
  output logic [CNT_W-1:0]   cur_count
);

  seq_state_t state;
  logic load, elem_done, take_io, take_mem, last_elem;
  logic word_q, dec_q, input_q;
  logic refuse, onchip;
  logic [PORT_AW-1:0] port_q;

  assign onchip = (st_port >= ONCHIP_LO) && (st_port <= ONCHIP_HI);
  assign refuse = st_word && bus_narrow && !onchip;

  blkio_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .refuse     (refuse),
    .zero_count (st_count == '0),
    .st_input   (st_input),
    .input_q    (input_q),
    .last_elem  (last_elem),
    .irq_req    (irq_req),
    .resume     (resume),
    .io_ready   (io_ready),
    .mem_ready  (mem_ready),
    .state      (state),
    .load       (load),
    .elem_done  (elem_done),
    .take_io    (take_io),
    .take_mem   (take_mem),
    .done       (done),
    .err        (err)
  );

  blkio_regs #(.PORT_AW(PORT_AW), .MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .elem_done (elem_done),
    .ld_port   (st_port),
    .ld_mem    (st_mem),
    .ld_count  (st_count),
    .ld_word   (st_word),
    .ld_dec    (st_dec),
    .ld_input  (st_input),
    .port_q    (port_q),
    .mem_q     (cur_mem),
    .count_q   (cur_count),
    .word_q    (word_q),
    .dec_q     (dec_q),
    .input_q   (input_q),
    .last_elem (last_elem)
  );

  blkio_lane u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .word      (word_q),
    .take_io   (take_io),
    .take_mem  (take_mem),
    .io_rdata  (io_rdata),
    .mem_rdata (mem_rdata),
    .io_wdata  (io_wdata),
    .mem_wdata (mem_wdata)
  );

  assign io_req   = (state == S_IO_RD)  || (state == S_IO_WR);
  assign io_we    = (state == S_IO_WR);
  assign io_word  = word_q;
  assign io_addr  = port_q;
  assign mem_req  = (state == S_MEM_RD) || (state == S_MEM_WR);
  assign mem_we   = (state == S_MEM_WR);
  assign mem_word = word_q;
  assign mem_addr = cur_mem;
  assign busy     = (state != S_IDLE);
  assign paused   = (state == S_PAUSE);

  logic unused_dec;
  assign unused_dec = dec_q;

endmodule

// File: rtl/blkio_chk.sv
module blkio_chk #(
  parameter int PORT_AW = 16,
  parameter int MEM_AW  = 16,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               paused,
  input logic               io_req,
  input logic               io_we,
  input logic               io_word,
  input logic [PORT_AW-1:0] io_addr,
  input logic [15:0]        io_wdata,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_word,
  input logic [15:0]        mem_wdata,
  input logic               io_ready,
  input logic               mem_ready,
  input logic               err,
  input logic               elem_done,
  input logic [MEM_AW-1:0]  cur_mem,
  input logic [CNT_W-1:0]   cur_count
);

  AST_PORT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(io_addr)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> cur_count == CNT_W'($past(cur_count) - 1'b1)); // R3

  AST_BYTE_IO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_we && !io_word |-> io_wdata[15:8] == 8'h00); // R4

  AST_BYTE_MEM_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_word |-> mem_wdata[15:8] == 8'h00); // R5

  AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && mem_req)); // R7

  AST_IO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(io_req) && !$past(io_ready) && busy && !paused |-> io_req); // R7

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_req) && !$past(mem_ready) && busy && !paused |-> mem_req); // R7

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !io_req && !mem_req); // R8

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    paused && $past(paused) |-> $stable(cur_mem) && $stable(cur_count)); // R8

  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !io_req && !mem_req); // R9

endmodule

bind blkio_seq blkio_chk #(.PORT_AW(PORT_AW), .MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .paused    (paused),
  .io_req    (io_req),
  .io_we     (io_we),
  .io_word   (io_word),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_word  (mem_word),
  .mem_wdata (mem_wdata),
  .io_ready  (io_ready),
  .mem_ready (mem_ready),
  .err       (err),
  .elem_done (elem_done),
  .cur_mem   (cur_mem),
  .cur_count (cur_count)
);

// File: tb/test_blkio_seq.sv
module test_blkio_seq;

  localparam int PAW = 8;
  localparam int MAW = 8;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PAW-1:0] st_port = '0;
  logic [MAW-1:0] st_mem = '0;
  logic [CW-1:0]  st_count = '0;
  logic st_word = 1'b0, st_dec = 1'b0, st_input = 1'b0;
  logic bus_narrow = 1'b0, irq_req = 1'b0, resume = 1'b0;
  logic io_req, io_we, io_word, mem_req, mem_we, mem_word;
  logic [PAW-1:0] io_addr;
  logic [MAW-1:0] mem_addr, cur_mem;
  logic [CW-1:0]  cur_count;
  logic [15:0] io_wdata, mem_wdata;
  logic [15:0] io_rdata = '0, mem_rdata = '0;
  logic io_ready = 1'b0, mem_ready = 1'b0;
  logic busy, paused, done, err;

  blkio_seq #(.PORT_AW(PAW), .MEM_AW(MAW), .CNT_W(CW),
              .ONCHIP_LO(8'hF0), .ONCHIP_HI(8'hFF)) i_blkio_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .st_port(st_port), .st_mem(st_mem),
    .st_count(st_count), .st_word(st_word), .st_dec(st_dec), .st_input(st_input),
    .bus_narrow(bus_narrow), .irq_req(irq_req), .resume(resume),
    .io_req(io_req), .io_we(io_we), .io_word(io_word), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .paused(paused), .done(done), .err(err),
    .cur_mem(cur_mem), .cur_count(cur_count));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;

  // Bench-side peripheral and memory models
  logic [7:0]  mem_m [256];
  logic [15:0] io_src [16];
  logic [15:0] io_log [16];
  logic        trace [64];
  int io_n = 0, mem_n = 0, ev_n = 0;
  int io_wait = 0, mem_wait = 0, io_cnt = 0, mem_cnt = 0;
  int port_err = 0, lane_err = 0;
  logic [PAW-1:0] exp_port = '0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (io_req) begin
        if (io_addr !== exp_port) port_err++;
        if (io_cnt >= io_wait) begin
          io_ready = 1'b1;
          if (io_we) io_log[io_n] = io_wdata;
          else       io_rdata = io_src[io_n];
          io_n++;
          if (ev_n < 64) trace[ev_n] = 1'b0;
          ev_n++;
        end else io_ready = 1'b0;
        io_cnt++;
      end else begin
        io_ready = 1'b0;
        io_cnt = 0;
      end
      if (mem_req) begin
        if (mem_cnt >= mem_wait) begin
          mem_ready = 1'b1;
          if (mem_we) begin
            mem_m[mem_addr] = mem_wdata[7:0];
            if (mem_word) mem_m[8'(mem_addr + 8'd1)] = mem_wdata[15:8];
            else if (mem_wdata[15:8] != 8'h00) lane_err++;
          end else begin
            mem_rdata = mem_word ? {mem_m[8'(mem_addr + 8'd1)], mem_m[mem_addr]}
                                 : {8'hCC, mem_m[mem_addr]};
          end
          mem_n++;
          if (ev_n < 64) trace[ev_n] = 1'b1;
          ev_n++;
        end else mem_ready = 1'b0;
        mem_cnt++;
      end else begin
        mem_ready = 1'b0;
        mem_cnt = 0;
      end
    end
  end

  task automatic clear_model();
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    io_n = 0; mem_n = 0; ev_n = 0; port_err = 0; lane_err = 0;
  endtask

  task automatic kick(input logic [PAW-1:0] p, input logic [MAW-1:0] m, input logic [CW-1:0] n,
                      input logic w, input logic d, input logic inp);
    @(negedge clk);
    st_port = p; st_mem = m; st_count = n; st_word = w; st_dec = d; st_input = inp;
    exp_port = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output logic saw_done);
    saw_done = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin saw_done = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_order(input logic first_mem, input int n, input string tag);
    logic ok;
    ok = (ev_n == 2 * n);
    for (int i = 0; i < 2 * n && i < 64; i++)
      if (trace[i] != (first_mem ^ logic'(i % 2))) ok = 1'b0;
    chk(ok, tag, ev_n, 2 * n);
  endtask

  task automatic t_reset();
    chk(!busy && !paused && !done && !err, "R3 reset idle", {busy, paused, done, err}, 0);
    chk(!io_req && !mem_req, "R7 reset no request", {io_req, mem_req}, 0);
  endtask

  task automatic t_in_byte_inc();
    logic fin;
    clear_model();
    io_wait = 1; mem_wait = 0;
    io_src[0] = 16'h55A0; io_src[1] = 16'h55A1; io_src[2] = 16'h55A2;
    kick(8'h12, 8'h10, 4'd3, 1'b0, 1'b0, 1'b1);
    wait_end(fin);
    chk(fin, "R3 done pulse after byte input", fin, 1);
    @(negedge clk);
    chk(!busy, "R3 idle after run", busy, 0);
    chk(cur_count == 0, "R3 count exhausted", cur_count, 0);
    chk({mem_m[8'h10], mem_m[8'h11], mem_m[8'h12]} == 24'hA0A1A2, "R4 byte input lane",
        {mem_m[8'h10], mem_m[8'h11], mem_m[8'h12]}, 24'hA0A1A2);
    chk(mem_m[8'h13] == 8'h00, "R4 neighbour untouched", mem_m[8'h13], 0);
    chk(lane_err == 0, "R5 byte memory write upper lane zero", lane_err, 0);
    chk(cur_mem == 8'h13, "R2 byte increment", cur_mem, 8'h13);
    chk(port_err == 0, "R1 port address fixed", port_err, 0);
    check_order(1'b0, 3, "R7 input order io then mem");
  endtask

  task automatic t_in_byte_wrap();
    logic fin;
    clear_model();
    io_wait = 0; mem_wait = 2;
    io_src[0] = 16'hFF01; io_src[1] = 16'hFF02; io_src[2] = 16'hFF03;
    kick(8'h30, 8'h01, 4'd3, 1'b0, 1'b1, 1'b1);
    wait_end(fin);
    chk(fin, "R3 done after wrap run", fin, 1);
    chk({mem_m[8'h01], mem_m[8'h00], mem_m[8'hFF]} == 24'h010203, "R2 decrement across zero",
        {mem_m[8'h01], mem_m[8'h00], mem_m[8'hFF]}, 24'h010203);
    chk(cur_mem == 8'hFE, "R2 wrap final address", cur_mem, 8'hFE);
  endtask

  task automatic t_out_byte_dec();
    logic fin;
    clear_model();
    io_wait = 2; mem_wait = 1;
    mem_m[8'h40] = 8'h11; mem_m[8'h3F] = 8'h22; mem_m[8'h3E] = 8'h33; mem_m[8'h3D] = 8'h44;
    kick(8'h55, 8'h40, 4'd4, 1'b0, 1'b1, 1'b0);
    wait_end(fin);
    chk(fin, "R3 done after byte output", fin, 1);
    chk(io_n == 4, "R3 element count", io_n, 4);
    chk(io_log[0] == 16'h0011 && io_log[3] == 16'h0044, "R4 byte output on low lane",
        {io_log[0], io_log[3]}, 32'h00110044);
    chk(io_log[1] == 16'h0022 && io_log[2] == 16'h0033, "R5 byte memory read masked",
        {io_log[1], io_log[2]}, 32'h00220033);
    chk(cur_mem == 8'h3C, "R2 byte decrement", cur_mem, 8'h3C);
    check_order(1'b1, 4, "R7 output order mem then io");
  endtask

  task automatic t_in_word_inc();
    logic fin;
    clear_model();
    io_wait = 0; mem_wait = 0;
    io_src[0] = 16'h3412; io_src[1] = 16'h7856;
    kick(8'h12, 8'h80, 4'd2, 1'b1, 1'b0, 1'b1);
    wait_end(fin);
    chk(fin, "R3 word count is in elements", mem_n, 2);
    chk({mem_m[8'h81], mem_m[8'h80]} == 16'h1234, "R6 word input lanes",
        {mem_m[8'h81], mem_m[8'h80]}, 16'h1234);
    chk({mem_m[8'h83], mem_m[8'h82]} == 16'h5678, "R6 word input second",
        {mem_m[8'h83], mem_m[8'h82]}, 16'h5678);
    chk(cur_mem == 8'h84, "R2 word increment by two", cur_mem, 8'h84);
  endtask

  task automatic t_out_word_dec();
    logic fin;
    clear_model();
    io_wait = 1; mem_wait = 1;
    mem_m[8'h60] = 8'hEF; mem_m[8'h61] = 8'hBE; mem_m[8'h5E] = 8'hFE; mem_m[8'h5F] = 8'hCA;
    kick(8'h77, 8'h60, 4'd2, 1'b1, 1'b1, 1'b0);
    wait_end(fin);
    chk(fin, "R3 done after word output", fin, 1);
    chk(io_log[0] == 16'hEFBE, "R6 word output lanes", io_log[0], 16'hEFBE);
    chk(io_log[1] == 16'hFECA, "R6 word output second", io_log[1], 16'hFECA);
    chk(cur_mem == 8'h5C, "R2 word decrement by two", cur_mem, 8'h5C);
  endtask

  task automatic t_zero_count();
    clear_model();
    kick(8'h12, 8'h20, 4'd0, 1'b0, 1'b0, 1'b1);
    chk(done && !busy, "R10 zero count done next cycle", {done, busy}, 2'b10);
    repeat (3) @(negedge clk);
    chk(ev_n == 0 && !done, "R10 zero count no bus cycle", ev_n, 0);
  endtask

  task automatic t_refused();
    clear_model();
    bus_narrow = 1'b1;
    kick(8'h12, 8'h20, 4'd2, 1'b1, 1'b0, 1'b1);
    chk(err && !busy && !done, "R9 refused word start", {err, busy, done}, 3'b100);
    repeat (4) @(negedge clk);
    chk(ev_n == 0 && err, "R9 refused no bus cycle", ev_n, 0);
  endtask

  task automatic t_onchip_word();
    logic fin;
    clear_model();
    bus_narrow = 1'b1;
    io_src[0] = 16'hCDAB;
    kick(8'hF4, 8'h90, 4'd1, 1'b1, 1'b0, 1'b1);
    chk(!err, "R9 err cleared by next start", err, 0);
    wait_end(fin);
    chk(fin && {mem_m[8'h91], mem_m[8'h90]} == 16'hABCD, "R9 on-chip word allowed",
        {mem_m[8'h91], mem_m[8'h90]}, 16'hABCD);
    bus_narrow = 1'b0;
  endtask

  task automatic t_interrupt();
    logic fin, got;
    logic quiet;
    clear_model();
    io_wait = 1; mem_wait = 1;
    io_src[0] = 16'h0071; io_src[1] = 16'h0072; io_src[2] = 16'h0073;
    irq_req = 1'b1;
    kick(8'h12, 8'hA0, 4'd3, 1'b0, 1'b0, 1'b1);
    got = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (paused) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, "R8 pause at boundary", got, 1);
    chk(cur_count == 4'd2 && cur_mem == 8'hA1, "R8 state held at pause",
        {cur_count, cur_mem}, {4'd2, 8'hA1});
    chk(mem_m[8'hA0] == 8'h71 && ev_n == 2, "R8 first element complete", ev_n, 2);
    quiet = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (io_req || mem_req || !paused || cur_count != 4'd2) quiet = 1'b0;
    end
    chk(quiet, "R8 no request while paused", quiet, 1);
    irq_req = 1'b0;
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    wait_end(fin);
    chk(fin && mem_m[8'hA1] == 8'h72 && mem_m[8'hA2] == 8'h73, "R8 resume completes",
        {mem_m[8'hA1], mem_m[8'hA2]}, 16'h7273);
    chk(cur_mem == 8'hA3, "R8 resumed address", cur_mem, 8'hA3);
  endtask

  task automatic t_busy_start();
    logic fin;
    clear_model();
    io_wait = 2; mem_wait = 2;
    io_src[0] = 16'h0001; io_src[1] = 16'h0002; io_src[2] = 16'h0003;
    kick(8'h21, 8'hC0, 4'd3, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    st_port = 8'h99; st_mem = 8'h00; st_count = 4'd9; st_input = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end(fin);
    chk(fin && port_err == 0, "R11 start while busy ignored, port", port_err, 0);
    chk(cur_mem == 8'hC3 && io_n == 3, "R11 run unchanged", {cur_mem, 8'(io_n)}, 16'hC303);
    check_order(1'b0, 3, "R11 direction unchanged");
    chk(port_err == 0, "R1 port fixed through foreign start", port_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_in_byte_inc();
    t_in_byte_wrap();
    t_out_byte_dec();
    t_in_word_inc();
    t_out_word_dec();
    t_zero_count();
    t_refused();
    t_onchip_word();
    t_interrupt();
    t_busy_start();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule